// File: doc/BRIEF.md
# Microcontroller interrupt aggregation controller

This block gathers the interrupt sources of a small 8-bit microcontroller and turns them into two signals for the core. Three core sources are watched directly: an external pin with a selectable active edge, a group of four port pins that raise a flag whenever they differ from a compare copy, and a timer rollover pulse. Each core source has a sticky flag and an enable in one 8-bit control register that software reads and writes. A set of peripheral request lines, each already masked by its own enable, is ORed together and gated by a group enable bit.

The block drives `irq_o`, a registered request to the CPU that is qualified by the global enable bit. It also drives `wake_o`, a registered sleep wake-up that does not depend on the global enable. A sleeping core therefore wakes on any enabled pending source, and the global enable only decides whether it then takes the interrupt. The external pin and the port pins are passed through a two-flop synchronizer before any edge or change is detected. A port read strobe reloads the compare copy. A change that reaches the detector in the same cycle as a read is absorbed and raises no flag.

Top module: `irq_aggregator`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `ctl_rdata_o` reads 0 and `irq_o` and `wake_o` are low.
- R2: With `ext_rise_i`=1 a 0-to-1 change of `ext_pin_i` sets control bit 1. With `ext_rise_i`=0 a 1-to-0 change sets it. The flag is visible after the third rising clock edge following the pin change, not after the second. The opposite edge leaves bit 1 unchanged.
- R3: A one-cycle `tmr_ovf_i` pulse sets control bit 2 at the next rising clock edge.
- R4: When the synchronized `port_i` differs from the compare copy, control bit 0 is set, three edges after the pin change. The compare copy resets to 0. While the difference persists, bit 0 is set again on every edge, so a software clear does not stick until a `port_rd_i` strobe has reloaded the copy.
- R5: On an edge where `port_rd_i` is high, the compare copy takes the synchronized port value and no port-change flag is raised. A change that arrives at that edge is therefore missed.
- R6: Flag bits 2:0 change only by a control write or a hardware set. A write loads all 8 bits from `ctl_wdata_i`. If a hardware set and a write of 0 hit the same flag at the same edge, the flag ends up 1.
- R7: `irq_o` is registered. It equals bit 7 ANDed with the pending term, where the pending term is computed from the control register one cycle earlier. The pending term is (b0&b3)|(b1&b4)|(b2&b5)|(b6 & |(`per_req_i`&`per_en_i`)).
- R8: `wake_o` is the registered pending term of R7 with no global-enable term. It rises even when bit 7 is 0.
- R9: A peripheral line counts only when both its request bit and its enable bit are 1 and control bit 6 is 1.
- R10: Control register map: b0 port-change flag, b1 external flag, b2 timer flag, b3 port-change enable, b4 external enable, b5 timer enable, b6 peripheral group enable, b7 global enable. Every bit reads back as written when no hardware set occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| ext_rise_i | input | 1 | Edge select: 1 rising, 0 falling |
| port_i | input | PORT_W | Watched port pins, asynchronous |
| port_rd_i | input | 1 | Port read strobe, reloads the compare copy |
| tmr_ovf_i | input | 1 | Timer rollover pulse |
| per_req_i | input | NPER | Peripheral request flags |
| per_en_i | input | NPER | Peripheral enables |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register contents |
| irq_o | output | 1 | Registered interrupt request to the CPU |
| wake_o | output | 1 | Registered wake-up request |

## Verification
The assertions assume that `tmr_ovf_i`, `port_rd_i` and `ctl_we_i` are low while reset is applied, so that the first post-reset `$past` values are quiet. They also assume that the peripheral request lines are level flags held steady across an edge. The stimulus drives every input only just after a falling edge and keeps these strobes low during reset. It changes `ext_rise_i` only after the pin has been stable for several cycles, so that no stray edge is produced by the select alone.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned CTL_W = 8;

  // bit 7 down to bit 0
  typedef struct packed {
    logic glb_en;
    logic grp_en;
    logic tm_en;
    logic ex_en;
    logic pc_en;
    logic tm_f;
    logic ex_f;
    logic pc_f;
  } ctl_t;

  typedef struct packed {
    logic tm;
    logic ex;
    logic pc;
  } set_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic rise_sel_i,
  output logic evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign evt_o = rise_sel_i ? (lvl_i & ~prev_q) : (~lvl_i & prev_q);
endmodule

// File: rtl/irq_port_chg.sv
module irq_port_chg #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  input  logic         rd_i,
  output logic         evt_o
);
  logic [W-1:0] cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmp_q <= '0;
    else if (rd_i) cmp_q <= cur_i;
  end

  // read cycle swallows a coincident change
  assign evt_o = (cur_i != cmp_q) & ~rd_i;
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  set_t             set_i,
  output ctl_t             ctl_o
);
  ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = we_i ? ctl_t'(wdata_i) : ctl_q;
    // hardware set beats software clear
    ctl_d.pc_f = ctl_d.pc_f | set_i.pc;
    ctl_d.ex_f = ctl_d.ex_f | set_i.ex;
    ctl_d.tm_f = ctl_d.tm_f | set_i.tm;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_pkg::*;
#(
  parameter int NPER        = 8,
  parameter int PORT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_pin_i,
  input  logic              ext_rise_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              port_rd_i,
  input  logic              tmr_ovf_i,
  input  logic [NPER-1:0]   per_req_i,
  input  logic [NPER-1:0]   per_en_i,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  output logic [CTL_W-1:0]  ctl_rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int SW = PORT_W + 1;

  logic [SW-1:0]     sync_q;
  logic              ext_s;
  logic [PORT_W-1:0] port_s;
  logic              ext_evt, pc_evt;
  set_t              set;
  ctl_t              ctl;
  logic              core_pend, per_pend, pend;
  logic              irq_q, wake_q;

  irq_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ext_pin_i, port_i}),
    .q_o    (sync_q)
  );

  assign {ext_s, port_s} = sync_q;

  irq_edge_det u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (ext_s),
    .rise_sel_i (ext_rise_i),
    .evt_o      (ext_evt)
  );

  irq_port_chg #(.W(PORT_W)) u_pchg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cur_i  (port_s),
    .rd_i   (port_rd_i),
    .evt_o  (pc_evt)
  );

  assign set.pc = pc_evt;
  assign set.ex = ext_evt;
  assign set.tm = tmr_ovf_i;

  irq_ctl_reg u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl_we_i),
    .wdata_i (ctl_wdata_i),
    .set_i   (set),
    .ctl_o   (ctl)
  );

  assign core_pend = (ctl.pc_f & ctl.pc_en) | (ctl.ex_f & ctl.ex_en) | (ctl.tm_f & ctl.tm_en);
  assign per_pend  = ctl.grp_en & (|(per_req_i & per_en_i));
  assign pend      = core_pend | per_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= ctl.glb_en & pend;
      wake_q <= pend;
    end
  end

  assign ctl_rdata_o = ctl;
  assign irq_o       = irq_q;
  assign wake_o      = wake_q;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tmr_ovf_i,
  input logic       port_rd_i,
  input logic       ctl_we_i,
  input logic [7:0] ctl_wdata_i,
  input logic [7:0] ctl_rdata_o,
  input logic       irq_o,
  input logic       wake_o
);
  logic core_pend;
  assign core_pend = (ctl_rdata_o[0] & ctl_rdata_o[3]) | (ctl_rdata_o[1] & ctl_rdata_o[4]) |
                     (ctl_rdata_o[2] & ctl_rdata_o[5]);

  p_tmr_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tmr_ovf_i) |-> ctl_rdata_o[2]);

  for (genvar k = 0; k < 3; k++) begin : g_sticky
    p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(!ctl_we_i) && $past(ctl_rdata_o[k])) |-> ctl_rdata_o[k]);
  end

  p_rd_miss_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(port_rd_i && !ctl_rdata_o[0] && !(ctl_we_i && ctl_wdata_i[0])) |-> !ctl_rdata_o[0]);

  p_irq_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ctl_rdata_o[7]));

  p_irq_fire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctl_rdata_o[7] && ctl_rdata_o[1] && ctl_rdata_o[4]) |-> irq_o);

  p_wake_nogie_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctl_rdata_o[2] && ctl_rdata_o[5]) |-> wake_o);

  p_wake_under_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> wake_o);

  p_grp_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!ctl_rdata_o[6] && !core_pend) |-> !wake_o);
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tmr_ovf_i   (tmr_ovf_i),
  .port_rd_i   (port_rd_i),
  .ctl_we_i    (ctl_we_i),
  .ctl_wdata_i (ctl_wdata_i),
  .ctl_rdata_o (ctl_rdata_o),
  .irq_o       (irq_o),
  .wake_o      (wake_o)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0, sel = 1'b0, rd = 1'b0, tmr = 1'b0, we = 1'b0;
  logic [3:0] port = '0;
  logic [7:0] preq = '0, pen = '0, wd = '0;
  logic [7:0] rdata;
  logic       irq, wake;

  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_pin_i(pin), .ext_rise_i(sel),
    .port_i(port), .port_rd_i(rd), .tmr_ovf_i(tmr),
    .per_req_i(preq), .per_en_i(pen), .ctl_we_i(we), .ctl_wdata_i(wd),
    .ctl_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    we = 1'b1; wd = v;
    tick(1);
    we = 1'b0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // behavioural reference: pin history lists, mirrored register image
  bit       eh [$];
  bit [3:0] ph [$];
  bit [3:0] m_cmp;
  bit [7:0] m_reg;
  bit       m_irq, m_wake;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eh = {1'b0, 1'b0, 1'b0};
      ph = {4'h0, 4'h0};
      m_cmp = '0; m_reg = '0; m_irq = 0; m_wake = 0;
    end else begin
      bit seen_e, prior_e, ev_e, ev_p, pend;
      bit [3:0] seen_p;
      seen_e  = eh[1];
      prior_e = eh[2];
      seen_p  = ph[1];
      ev_e = sel ? (seen_e && !prior_e) : (!seen_e && prior_e);
      ev_p = (seen_p != m_cmp) && !rd;
      pend = (m_reg[0] && m_reg[3]) || (m_reg[1] && m_reg[4]) || (m_reg[2] && m_reg[5]) ||
             (m_reg[6] && ((preq & pen) != 0));
      m_wake = pend;
      m_irq  = pend && m_reg[7];
      if (rd) m_cmp = seen_p;
      if (we) m_reg = wd;
      m_reg[0] = m_reg[0] | ev_p;
      m_reg[1] = m_reg[1] | ev_e;
      m_reg[2] = m_reg[2] | tmr;
      eh.push_front(pin);  void'(eh.pop_back());
      ph.push_front(port); void'(ph.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rdata == m_reg, "R10 register image", rdata, m_reg);
      chk(irq == m_irq,   "R7 irq per cycle",   irq, m_irq);
      chk(wake == m_wake, "R8 wake per cycle",  wake, m_wake);
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    summary();
    $finish;
  end

  initial begin
    tick(3);
    chk(rdata == 8'h00, "R1 reset reg", rdata, 0);
    chk(!irq && !wake, "R1 reset outputs", {irq, wake}, 0);
    rst_n = 1'b1;
    tick(1);
    chk(rdata == 8'h00 && !irq && !wake, "R1 after release", {rdata, irq, wake}, 0);

    // R3 timer
    tmr = 1'b1; tick(1); tmr = 1'b0;
    chk(rdata == 8'h04, "R3 timer flag", rdata, 8'h04);
    tick(1);
    chk(!wake && !irq, "R8 disabled no wake", {irq, wake}, 0);

    wr(8'hA4);
    chk(rdata == 8'hA4, "R10 write readback", rdata, 8'hA4);
    tick(1);
    chk(irq && wake, "R7 timer irq", {irq, wake}, 3);
    tick(3);
    chk(rdata[2], "R6 sticky flag", rdata[2], 1);

    // R6 set beats clear
    we = 1'b1; wd = 8'hA0; tmr = 1'b1;
    tick(1);
    we = 1'b0; tmr = 1'b0;
    chk(rdata == 8'hA4, "R6 set wins", rdata, 8'hA4);
    wr(8'hA0);
    chk(rdata == 8'hA0, "R6 software clear", rdata, 8'hA0);
    tick(1);
    chk(!irq, "R7 cleared", irq, 0);

    // R8 wake without global enable
    wr(8'h24); tick(1);
    chk(wake && !irq, "R8 wake no gie", {irq, wake}, 1);
    wr(8'h00); tick(1);

    // R2 rising
    sel = 1'b1; pin = 1'b1;
    tick(2);
    chk(!rdata[1], "R2 not before 3rd edge", rdata[1], 0);
    tick(1);
    chk(rdata[1], "R2 rising sets", rdata[1], 1);
    wr(8'h10);
    chk(rdata == 8'h10, "R2 cleared", rdata, 8'h10);
    tick(2);
    pin = 1'b0; tick(5);
    chk(rdata == 8'h10, "R2 falling ignored in rise mode", rdata, 8'h10);
    sel = 1'b0; tick(2);
    pin = 1'b1; tick(5);
    chk(rdata == 8'h10, "R2 rising ignored in fall mode", rdata, 8'h10);
    pin = 1'b0; tick(3);
    chk(rdata == 8'h12, "R2 falling sets", rdata, 8'h12);
    tick(1);
    chk(wake && !irq, "R8 ext wake no gie", {irq, wake}, 1);
    wr(8'h92); tick(1);
    chk(irq, "R7 ext irq", irq, 1);
    wr(8'h00); tick(1);

    // R4 port change
    port = 4'b0100; tick(3);
    chk(rdata[0], "R4 change sets", rdata[0], 1);
    wr(8'h00);
    chk(rdata[0], "R4 mismatch resets flag", rdata[0], 1);
    rd = 1'b1; tick(1); rd = 1'b0;
    wr(8'h00);
    chk(rdata == 8'h00, "R4 clear after read", rdata, 0);
    tick(3);
    chk(!rdata[0], "R4 stays clear", rdata[0], 0);
    port = 4'b1100; tick(3);
    chk(rdata[0], "R4 upper pin change", rdata[0], 1);
    rd = 1'b1; tick(1); rd = 1'b0;
    wr(8'h00);

    // R5 coincident read loses the change
    port = 4'b1101; tick(2);
    rd = 1'b1; tick(1); rd = 1'b0;
    tick(3);
    chk(!rdata[0], "R5 missed change", rdata[0], 0);

    // R9 peripheral gating
    wr(8'hC0);
    preq = 8'h10; pen = 8'h00; tick(2);
    chk(!irq && !wake, "R9 per enable off", {irq, wake}, 0);
    pen = 8'h10; tick(2);
    chk(irq && wake, "R9 per enabled", {irq, wake}, 3);
    wr(8'h80); tick(1);
    chk(!irq && !wake, "R9 group off", {irq, wake}, 0);
    preq = 8'h00; pen = 8'h00;
    wr(8'h00);

    wr(8'h5A);
    chk(rdata == 8'h5A, "R10 field map", rdata, 8'h5A);
    tick(1);
    chk(wake && !irq, "R10 ext flag+en bits", {irq, wake}, 1);
    wr(8'h00); tick(2);

    summary();
    $finish;
  end
endmodule